// File: doc/BRIEF.md
# Register-Flag Instruction Execution Unit

This unit executes one instruction of a small control-program instruction set at a time. It holds three kinds of state: a file of 16-bit registers, a file of one-bit flags, and a 32-bit accumulator. Each instruction arrives on the input side as a decimal opcode and three 16-bit operand fields. The unit decodes the opcode, carries out the load, store, copy, arithmetic or logic operation on that state, and pulses `done` when the operation has finished. Instruction fetch, sequencing and branching are left to the logic that drives it.

The accumulator is 32 bits wide. It reaches the register file through a pair of neighbouring registers, n and n+1. Register n carries the upper half and register n+1 the lower half. Word operations on registers and single-bit boolean operations on flags share the same opcode space.

Multiply and divide are iterative and take several cycles. While one of them runs, `busy` is high. Every other instruction finishes in the cycle after it is accepted. The end-of-program opcode sets `halt`. From then on the unit ignores its instruction input until it is reset. Read ports for the register file, the flag file and the accumulator expose the state to the surrounding logic.

Top module: `rfx_unit`

## Requirements
- R1: After reset, every register, every flag and the accumulator read zero, and `busy`, `done`, `halt`, `ill` and `dz` are low.
- R2: Opcode 0 completes with `done` and `halt` high. `halt` then stays high until reset. While `halt` is high, the unit accepts no instruction, raises no `done` and changes no state.
- R3: Operand fields: `in_a` holds destination n, `in_b` holds m, n1 or the immediate, and `in_c` holds n2. Register and flag indices use the low log2(count) bits of their field. Opcode 1 writes `in_b` into register n. Opcode 11 adds `in_b[14:0]` to register n, ignores `in_b[15]`, and wraps modulo 2^16.
- R4: Opcode 2 loads the accumulator with {reg n, reg n+1}. Opcode 3 writes the accumulator's upper half to reg n and its lower half to reg n+1. In both, the index n+1 wraps modulo the register count.
- R5: Opcodes 5 and 6 decrement and increment reg n, wrapping modulo 2^16. Opcode 7 copies reg m into reg n. Opcode 8 copies flag m into flag n.
- R6: Opcodes 9 and 10 set and clear flag n. Opcode 25 writes the inverse of flag m into flag n. Opcodes 19 to 24 write the AND, NAND, NOR, XOR, XNOR and OR of flags n1 and n2 into flag n.
- R7: Opcodes 12 and 14 write reg n1 + reg n2 and reg n1 - reg n2 into reg n, wrapping modulo 2^16. Opcodes 27, 28 and 29 write the bitwise AND, OR and XOR of reg n1 and reg n2 into reg n. Opcode 26 writes the bitwise inverse of reg m into reg n.
- R8: Opcodes 13 and 15 add the pair {reg n, reg n+1} to the accumulator or subtract it from the accumulator, wrapping modulo 2^32.
- R9: Opcode 16 puts the full unsigned 32-bit product of reg n and reg m into the accumulator. `busy` is high from the cycle after acceptance until the cycle in which `done` rises.
- R10: Opcode 17 writes the unsigned quotient reg n1 / reg n2 into reg n. Opcode 18 replaces the accumulator with the unsigned quotient accumulator / reg n. Both run over several cycles with `busy` high.
- R11: A zero divisor in opcode 17 or 18 writes all ones to the destination. The instruction then completes one cycle after acceptance with `dz` high alongside `done`, and no other state changes.
- R12: Any opcode outside {0-3, 5-29}, including 4 and 30-255, completes one cycle after acceptance with `ill` high alongside `done` and changes no state.
- R13: The unit accepts an instruction when `in_valid` is high while `busy` and `halt` are low. A non-iterative instruction raises `done` in the next cycle. While `busy` is high, `in_valid` is ignored, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present on the operand inputs |
| in_op | input | 8 | Decimal opcode |
| in_a | input | 16 | Field n: destination index |
| in_b | input | 16 | Field m / n1 / immediate |
| in_c | input | 16 | Field n2 |
| busy | output | 1 | Iterative multiply or divide in progress |
| done | output | 1 | One-cycle completion pulse |
| halt | output | 1 | End of program reached |
| ill | output | 1 | Completing instruction was illegal (with done) |
| dz | output | 1 | Completing division had a zero divisor (with done) |
| rd_ridx | input | 4 | Register read index |
| rd_rdata | output | 16 | Register read data |
| rd_fidx | input | 4 | Flag read index |
| rd_fdata | output | 1 | Flag read data |
| acc | output | 32 | Accumulator value |

## Verification
The bench targets the following corner cases:
- Wraparound: increment of 0xFFFF, decrement of 0, accumulator add and subtract across 2^32, and a pair at the last register index that must wrap to register 0. A design that fails here would leak a carry or write the wrong register.
- The immediate add with bit 15 set. A design that fails here would add 0x8000 more than it should.
- The largest multiply (0xFFFF squared) and divides by 1, by a large divisor and from a full 32-bit accumulator. A design that fails here would drop a product bit or a quotient bit in the iteration.
- Zero divisors in both divide forms, illegal opcodes, instructions offered while a multiply is running, and instructions offered after the end-of-program opcode. A design that fails here would leave partial results, raise an extra `done`, or alter state that must stay frozen.

// File: rtl/rfx_unit.sv
module rfx_unit #(
  parameter int W    = 16,
  parameter int NREG = 16,
  parameter int NFLG = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [7:0]                 in_op,
  input  logic [W-1:0]               in_a,
  input  logic [W-1:0]               in_b,
  input  logic [W-1:0]               in_c,
  output logic                       busy,
  output logic                       done,
  output logic                       halt,
  output logic                       ill,
  output logic                       dz,
  input  logic [$clog2(NREG)-1:0]    rd_ridx,
  output logic [W-1:0]               rd_rdata,
  input  logic [$clog2(NFLG)-1:0]    rd_fidx,
  output logic                       rd_fdata,
  output logic [2*W-1:0]             acc
);
  localparam int RI = $clog2(NREG);
  localparam int FI = $clog2(NFLG);
  localparam int AW = 2 * W;
  localparam int CW = $clog2(AW + 1);

  logic [W-1:0]    rf [NREG];
  logic [NFLG-1:0] ff;
  logic [AW-1:0]   acc_q;

  wire accept = in_valid && !busy && !halt;

  wire [RI-1:0] ra  = in_a[RI-1:0];
  wire [RI-1:0] ra1 = ra + RI'(1);
  wire [RI-1:0] rb  = in_b[RI-1:0];
  wire [RI-1:0] rc  = in_c[RI-1:0];
  wire [FI-1:0] fa  = in_a[FI-1:0];

  wire [W-1:0]  va   = rf[ra];
  wire [W-1:0]  vb   = rf[rb];
  wire [W-1:0]  vc   = rf[rc];
  wire [AW-1:0] pair = {va, rf[ra1]};
  wire          fb   = ff[in_b[FI-1:0]];
  wire          fc   = ff[in_c[FI-1:0]];

  logic unused_fields;
  assign unused_fields = ^{in_a, in_c};

  logic          wr_r, wr_pair, wr_f, wr_acc;
  logic          op_end, op_ill, op_dz, op_mul, op_div, op_div32;
  logic [W-1:0]  r_val;
  logic          f_val;
  logic [AW-1:0] acc_val;

  always_comb begin
    wr_r = 1'b0; wr_pair = 1'b0; wr_f = 1'b0; wr_acc = 1'b0;
    op_end = 1'b0; op_ill = 1'b0; op_dz = 1'b0;
    op_mul = 1'b0; op_div = 1'b0; op_div32 = 1'b0;
    r_val = '0; f_val = 1'b0; acc_val = '0;
    case (in_op)
      8'd0:  op_end = 1'b1;
      8'd1:  begin wr_r = 1'b1; r_val = in_b; end
      8'd2:  begin wr_acc = 1'b1; acc_val = pair; end
      8'd3:  wr_pair = 1'b1;
      8'd5:  begin wr_r = 1'b1; r_val = va - W'(1); end
      8'd6:  begin wr_r = 1'b1; r_val = va + W'(1); end
      8'd7:  begin wr_r = 1'b1; r_val = vb; end
      8'd8:  begin wr_f = 1'b1; f_val = fb; end
      8'd9:  begin wr_f = 1'b1; f_val = 1'b1; end
      8'd10: begin wr_f = 1'b1; f_val = 1'b0; end
      8'd11: begin wr_r = 1'b1; r_val = va + {1'b0, in_b[W-2:0]}; end
      8'd12: begin wr_r = 1'b1; r_val = vb + vc; end
      8'd13: begin wr_acc = 1'b1; acc_val = acc_q + pair; end
      8'd14: begin wr_r = 1'b1; r_val = vb - vc; end
      8'd15: begin wr_acc = 1'b1; acc_val = acc_q - pair; end
      8'd16: op_mul = 1'b1;
      8'd17: if (vc == '0) begin wr_r = 1'b1; r_val = '1; op_dz = 1'b1; end
             else op_div = 1'b1;
      8'd18: if (va == '0) begin wr_acc = 1'b1; acc_val = '1; op_dz = 1'b1; end
             else op_div32 = 1'b1;
      8'd19: begin wr_f = 1'b1; f_val = fb & fc; end
      8'd20: begin wr_f = 1'b1; f_val = ~(fb & fc); end
      8'd21: begin wr_f = 1'b1; f_val = ~(fb | fc); end
      8'd22: begin wr_f = 1'b1; f_val = fb ^ fc; end
      8'd23: begin wr_f = 1'b1; f_val = ~(fb ^ fc); end
      8'd24: begin wr_f = 1'b1; f_val = fb | fc; end
      8'd25: begin wr_f = 1'b1; f_val = ~fb; end
      8'd26: begin wr_r = 1'b1; r_val = ~vb; end
      8'd27: begin wr_r = 1'b1; r_val = vb & vc; end
      8'd28: begin wr_r = 1'b1; r_val = vb | vc; end
      8'd29: begin wr_r = 1'b1; r_val = vb ^ vc; end
      default: op_ill = 1'b1;
    endcase
  end

  logic [CW-1:0] cnt;
  logic [AW-1:0] mc, prod;
  logic [W-1:0]  mp, rem;
  logic          md_div, md_acc;
  logic [RI-1:0] md_idx;

  wire [AW-1:0] pnext = prod + (mp[0] ? mc : '0);
  wire [W:0]    rsh   = {rem, mc[AW-1]};
  wire          ge    = rsh >= {1'b0, mp};
  wire [W:0]    rdif  = rsh - {1'b0, mp};
  wire [W-1:0]  rnext = ge ? rdif[W-1:0] : rsh[W-1:0];
  wire [AW-1:0] qnext = {mc[AW-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      ff <= '0; acc_q <= '0;
      busy <= 1'b0; done <= 1'b0; halt <= 1'b0; ill <= 1'b0; dz <= 1'b0;
      cnt <= '0; mc <= '0; prod <= '0; mp <= '0; rem <= '0;
      md_div <= 1'b0; md_acc <= 1'b0; md_idx <= '0;
    end else begin
      done <= 1'b0; ill <= 1'b0; dz <= 1'b0;
      if (accept) begin
        done <= !(op_mul || op_div || op_div32);
        ill  <= op_ill;
        dz   <= op_dz;
        if (op_end) halt <= 1'b1;
        if (wr_r) rf[ra] <= r_val;
        if (wr_pair) begin
          rf[ra]  <= acc_q[AW-1:W];
          rf[ra1] <= acc_q[W-1:0];
        end
        if (wr_f) ff[fa] <= f_val;
        if (wr_acc) acc_q <= acc_val;
        if (op_mul) begin
          busy <= 1'b1; md_div <= 1'b0; md_acc <= 1'b1; cnt <= CW'(W);
          mc <= {{W{1'b0}}, va}; mp <= vb; prod <= '0;
        end
        if (op_div) begin
          busy <= 1'b1; md_div <= 1'b1; md_acc <= 1'b0; md_idx <= ra; cnt <= CW'(W);
          mc <= {vb, {W{1'b0}}}; mp <= vc; rem <= '0;
        end
        if (op_div32) begin
          busy <= 1'b1; md_div <= 1'b1; md_acc <= 1'b1; cnt <= CW'(AW);
          mc <= acc_q; mp <= va; rem <= '0;
        end
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (md_div) begin
          mc <= qnext; rem <= rnext;
        end else begin
          prod <= pnext; mc <= mc << 1; mp <= mp >> 1;
        end
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (md_acc) acc_q <= md_div ? qnext : pnext;
          else rf[md_idx] <= qnext[W-1:0];
        end
      end
    end
  end

  assign rd_rdata = rf[rd_ridx];
  assign rd_fdata = ff[rd_fidx];
  assign acc      = acc_q;
endmodule

// File: rtl/rfx_unit_chk.sv
module rfx_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_op,
  input logic       busy,
  input logic       done,
  input logic       halt,
  input logic       ill,
  input logic       dz
);
  wire acc_ok = in_valid && !busy && !halt;

  p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !done);
  p_mul_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && in_op == 8'd16) |=> (busy && !done));
  p_dz_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dz |-> done);
  p_ill_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ill |-> (done && !dz));
  p_single_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && in_op != 8'd16 && in_op != 8'd17 && in_op != 8'd18) |=> done);
  p_busy_excl_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

bind rfx_unit rfx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .busy(busy), .done(done), .halt(halt), .ill(ill), .dz(dz)
);

// File: tb/rfx_unit_bench.sv
`timescale 1ns/1ps
module rfx_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_op = '0;
  logic [15:0] in_a = '0, in_b = '0, in_c = '0;
  logic        busy, done, halt, ill, dz, rd_fdata;
  logic [3:0]  rd_ridx = '0, rd_fidx = '0;
  logic [15:0] rd_rdata;
  logic [31:0] acc;

  always #2 clk = ~clk;

  rfx_unit u_rfx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .busy(busy), .done(done), .halt(halt), .ill(ill), .dz(dz),
    .rd_ridx(rd_ridx), .rd_rdata(rd_rdata), .rd_fidx(rd_fidx),
    .rd_fdata(rd_fdata), .acc(acc)
  );

  int checks = 0, errs = 0, pending = 0;
  logic [2:0] q_exp [$];
  string      q_tag [$];

  logic [15:0] m_reg [16];
  logic [15:0] m_flg;
  logic [31:0] m_acc;
  logic        m_halt;

  task automatic fail(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    errs++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && done) begin
      checks++;
      if (q_exp.size() == 0) begin
        fail("R2/R13", "unexpected done", 32'(done), 32'd0);
      end else begin
        logic [2:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if ({ill, dz, halt} !== e) fail(t, "{ill,dz,halt} at done", 32'({ill, dz, halt}), 32'(e));
        pending--;
      end
    end
  end

  task automatic model(input logic [7:0] op, input logic [15:0] a, b, c,
                       output bit e_ill, output bit e_dz, output bit multi);
    int n, n1, n2, nx;
    n = int'(a[3:0]); n1 = int'(b[3:0]); n2 = int'(c[3:0]); nx = (n + 1) % 16;
    e_ill = 0; e_dz = 0; multi = 0;
    case (op)
      0:  m_halt = 1'b1;
      1:  m_reg[n] = b;
      2:  m_acc = {m_reg[n], m_reg[nx]};
      3:  begin m_reg[n] = m_acc[31:16]; m_reg[nx] = m_acc[15:0]; end
      5:  m_reg[n] = m_reg[n] - 16'd1;
      6:  m_reg[n] = m_reg[n] + 16'd1;
      7:  m_reg[n] = m_reg[n1];
      8:  m_flg[n] = m_flg[n1];
      9:  m_flg[n] = 1'b1;
      10: m_flg[n] = 1'b0;
      11: m_reg[n] = m_reg[n] + (b & 16'h7fff);
      12: m_reg[n] = m_reg[n1] + m_reg[n2];
      13: m_acc = m_acc + {m_reg[n], m_reg[nx]};
      14: m_reg[n] = m_reg[n1] - m_reg[n2];
      15: m_acc = m_acc - {m_reg[n], m_reg[nx]};
      16: begin m_acc = {16'h0, m_reg[n]} * {16'h0, m_reg[n1]}; multi = 1; end
      17: if (m_reg[n2] == 0) begin m_reg[n] = 16'hffff; e_dz = 1; end
          else begin m_reg[n] = m_reg[n1] / m_reg[n2]; multi = 1; end
      18: if (m_reg[n] == 0) begin m_acc = 32'hffffffff; e_dz = 1; end
          else begin m_acc = m_acc / {16'h0, m_reg[n]}; multi = 1; end
      19: m_flg[n] = m_flg[n1] & m_flg[n2];
      20: m_flg[n] = ~(m_flg[n1] & m_flg[n2]);
      21: m_flg[n] = ~(m_flg[n1] | m_flg[n2]);
      22: m_flg[n] = m_flg[n1] ^ m_flg[n2];
      23: m_flg[n] = ~(m_flg[n1] ^ m_flg[n2]);
      24: m_flg[n] = m_flg[n1] | m_flg[n2];
      25: m_flg[n] = ~m_flg[n1];
      26: m_reg[n] = ~m_reg[n1];
      27: m_reg[n] = m_reg[n1] & m_reg[n2];
      28: m_reg[n] = m_reg[n1] | m_reg[n2];
      29: m_reg[n] = m_reg[n1] ^ m_reg[n2];
      default: e_ill = 1;
    endcase
  endtask

  task automatic compare_all(input string tag);
    bit bad = 0;
    checks++;
    for (int i = 0; i < 16; i++) begin
      rd_ridx = 4'(i); rd_fidx = 4'(i); #1;
      if (rd_rdata !== m_reg[i]) begin bad = 1; $display("FAIL %s reg %0d: actual %h expected %h", tag, i, rd_rdata, m_reg[i]); end
      if (rd_fdata !== m_flg[i]) begin bad = 1; $display("FAIL %s flag %0d: actual %h expected %h", tag, i, rd_fdata, m_flg[i]); end
    end
    if (acc !== m_acc) begin bad = 1; $display("FAIL %s acc: actual %h expected %h", tag, acc, m_acc); end
    if (halt !== m_halt) begin bad = 1; $display("FAIL %s halt: actual %h expected %h", tag, halt, m_halt); end
    if (bad) errs++;
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] a, b, c,
                       input string tag, input bit poke = 0);
    bit e_ill, e_dz, multi;
    model(op, a, b, c, e_ill, e_dz, multi);
    q_exp.push_back({e_ill, e_dz, m_halt});
    q_tag.push_back(tag);
    pending++;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (multi) begin
      if (busy !== 1'b1 || pending == 0) fail("R9", "busy after iterative accept", 32'(busy), 32'd1);
    end else if (pending != 0) begin
      fail("R13", "done one cycle after accept", 32'd0, 32'd1);
    end
    if (poke && multi) begin
      in_valid = 1'b1; in_op = 8'd1; in_a = 16'd9; in_b = 16'haaaa;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
    end
    while (pending != 0) @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset;
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_flg = '0; m_acc = '0; m_halt = 1'b0; pending = 0;
    q_exp.delete(); q_tag.delete();
    @(negedge clk);
    checks++;
    if ({busy, done, halt, ill, dz} !== 5'b0) fail("R1", "status after reset", 32'({busy, done, halt, ill, dz}), 32'd0);
    compare_all("R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    do_reset();
    // R3 immediate load and add with bit 15 ignored
    issue(1, 0, 16'h1234, 0, "R3");
    issue(1, 1, 16'hfffe, 0, "R3");
    issue(11, 1, 16'h8003, 0, "R3");
    issue(1, 15, 16'hbeef, 0, "R3");
    // R4 accumulator pair, including wrap from 15 to 0
    issue(2, 0, 0, 0, "R4");
    issue(3, 4, 0, 0, "R4");
    issue(2, 15, 0, 0, "R4");
    issue(3, 7, 0, 0, "R4");
    // R5 inc/dec wrap and copies
    issue(1, 2, 16'hffff, 0, "R5");
    issue(6, 2, 0, 0, "R5");
    issue(5, 2, 0, 0, "R5");
    issue(7, 3, 15, 0, "R5");
    // R6 flags
    issue(9, 1, 0, 0, "R6");
    issue(9, 3, 0, 0, "R6");
    issue(9, 6, 0, 0, "R6");
    issue(10, 6, 0, 0, "R6");
    issue(8, 5, 3, 0, "R5");
    issue(25, 7, 1, 0, "R6");
    issue(25, 9, 2, 0, "R6");
    for (int op = 19; op <= 24; op++) begin
      issue(8'(op), 10, 1, 3, "R6");
      issue(8'(op), 11, 1, 2, "R6");
      issue(8'(op), 12, 2, 4, "R6");
    end
    // R7 register arithmetic and bitwise
    issue(1, 5, 16'hf0f0, 0, "R7");
    issue(1, 6, 16'h3c3c, 0, "R7");
    issue(12, 8, 5, 6, "R7");
    issue(14, 9, 6, 5, "R7");
    issue(27, 10, 5, 6, "R7");
    issue(28, 11, 5, 6, "R7");
    issue(29, 12, 5, 6, "R7");
    issue(26, 13, 5, 0, "R7");
    // R8 accumulator add/sub with wrap
    issue(1, 4, 16'hffff, 0, "R8");
    issue(1, 5, 16'hffff, 0, "R8");
    issue(2, 4, 0, 0, "R8");
    issue(1, 6, 16'h0000, 0, "R8");
    issue(1, 7, 16'h0002, 0, "R8");
    issue(13, 6, 0, 0, "R8");
    issue(15, 6, 0, 0, "R8");
    issue(15, 6, 0, 0, "R8");
    // R9 multiply, with instructions offered while busy (R13)
    issue(16, 4, 5, 0, "R9");
    issue(16, 8, 9, 0, "R9");
    issue(16, 0, 14, 0, "R9/R13", 1);
    issue(1, 14, 16'd0, 0, "R9");
    issue(16, 0, 14, 0, "R9");
    // R10 divides
    issue(1, 1, 16'd1000, 0, "R10");
    issue(1, 2, 16'd7, 0, "R10");
    issue(17, 3, 1, 2, "R10");
    issue(1, 2, 16'd1, 0, "R10");
    issue(1, 1, 16'hffff, 0, "R10");
    issue(17, 3, 1, 2, "R10");
    issue(1, 2, 16'hfff0, 0, "R10");
    issue(17, 3, 1, 2, "R10");
    issue(1, 4, 16'hffff, 0, "R10");
    issue(1, 5, 16'hffff, 0, "R10");
    issue(2, 4, 0, 0, "R10");
    issue(1, 2, 16'h0010, 0, "R10");
    issue(18, 2, 0, 0, "R10");
    issue(1, 2, 16'hfffe, 0, "R10");
    issue(18, 2, 0, 0, "R10");
    // R11 zero divisors
    issue(1, 14, 16'd0, 0, "R11");
    issue(17, 3, 1, 14, "R11");
    issue(18, 14, 0, 0, "R11");
    // R12 illegal opcodes
    issue(4, 1, 16'h5555, 0, "R12");
    issue(30, 1, 16'h5555, 2, "R12");
    issue(255, 1, 16'h5555, 2, "R12");
    // R2 end of program, then ignored traffic
    issue(0, 0, 0, 0, "R2");
    @(negedge clk);
    in_valid = 1'b1; in_op = 8'd1; in_a = 16'd9; in_b = 16'h1111;
    repeat (4) @(negedge clk);
    in_op = 8'd16;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R2");
    // R1 reset clears everything after halt
    do_reset();
    issue(1, 3, 16'h00aa, 0, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule